// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It reads a three-level page table that sits in memory. A request brings in the virtual address, and the block captures the root table pointer at the same moment. From there it issues one 32-bit word read per level through a request/response memory port and decodes each entry it gets back. An entry can end the walk with a translation, send the walk to the next table, or end it with a fault.

A terminal mapping may appear at level one, two or three. It covers 16 MB, 256 KB or 4 KB respectively. The walk therefore takes one, two or three memory reads, and the number of virtual address bits copied into the result changes with the level. The walker handles one translation at a time. Completion is reported with a single-cycle pulse that carries the physical address and a fault flag.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done` and `mem_req_valid` are low.
- R2: A request is taken only when `busy` is low. `busy` is high in the cycle after acceptance. A `req_valid` seen while busy is ignored and does not change the result of the walk in progress. `busy` is low in the cycle after the `done` pulse.
- R3: The first read goes to `root_ptr + vaddr[31:24]*4`.
- R4: An entry type sits in bits [1:0]. The encodings are 0 invalid, 1 next-table pointer, 2 mapping and 3 invalid. A pointer names its next table as `entry & ~3`. The level-two read uses index `vaddr[23:18]` and the level-three read uses index `vaddr[17:12]`, each scaled by 4 and added to that base.
- R5: A memory request stays valid with a stable address until `mem_req_ready` is high. Each level visited causes exactly one read, and no read occurs after the terminating entry.
- R6: A mapping at level one gives `{entry[31:24], vaddr[23:0]}`.
- R7: A mapping at level two gives `{entry[31:18], vaddr[17:0]}`.
- R8: A mapping at level three gives `{entry[31:12], vaddr[11:0]}`. Whatever the level, `paddr[11:0]` equals `vaddr[11:0]` on a successful translation.
- R9: An entry of type 0 or 3 at any level ends the walk with `done_fault` high and `done_paddr` zero.
- R10: A pointer entry found at level three ends the walk with a fault.
- R11: `done` is a one-cycle pulse. It is high in the cycle right after the clock edge that takes the final memory response.
- R12: For random table contents and addresses, every result matches a table walk computed from R3 to R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ptr | input | 32 | Physical base of the first-level table, captured when a request is taken |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_paddr | output | 32 | Physical address (zero on fault) |
| done_fault | output | 1 | Walk ended on an invalid entry |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data is returned |
| mem_rsp_data | input | 32 | Entry word |

## Verification
`busy` rises one cycle after the edge that takes a request. The final memory response is sampled on one edge, and the `done` pulse with its address and fault flag follows one cycle later. The bench's memory model records the cycle in which it raises each response, and the bench samples on falling edges, so the pulse must appear exactly one cycle after the last response and be gone in the next. The model also logs every accepted read address and compares it with the expected walk, under random ready stalls and response latencies.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned VA_W      = 32;
    localparam int unsigned PA_W      = 32;
    localparam int unsigned ENT_SHIFT = 2;   // log2 of entry size in bytes
    localparam int unsigned PG_OFF_W  = 12;
    localparam int unsigned NUM_LVL   = 3;
    localparam int unsigned LVL_W     = $clog2(NUM_LVL + 1);

    localparam int unsigned IDX_W [NUM_LVL] = '{8, 6, 6};

    // Lowest virtual address bit of the index used at level l.
    function automatic int unsigned lvl_shift(input int unsigned l);
        int unsigned s;
        s = PG_OFF_W;
        for (int unsigned k = l + 1; k < NUM_LVL; k++) begin
            s += IDX_W[k];
        end
        return s;
    endfunction

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_TABLE   = 2'd1,
        ET_MAP     = 2'd2,
        ET_RSVD    = 2'd3
    } ent_type_e;

    typedef enum logic [1:0] {
        K_DESCEND = 2'd0,
        K_MAP     = 2'd1,
        K_FAULT   = 2'd2
    } ent_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_AWAIT = 2'd2
    } walk_st_e;

    typedef struct packed {
        walk_st_e          st;
        logic [LVL_W-1:0]  lvl;
        logic [PA_W-1:0]   base;
        logic [VA_W-1:0]   va;
        logic              done;
        logic              fault;
        logic [PA_W-1:0]   paddr;
    } walk_t;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
(
    input  logic [PA_W-1:0]  base,
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] lvl,
    output logic [PA_W-1:0]  addr
);

    logic [PA_W-1:0] cand [NUM_LVL];

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        localparam int unsigned SH = lvl_shift(g);
        localparam int unsigned IW = IDX_W[g];
        logic [IW-1:0] idx;
        assign idx     = va[SH +: IW];
        assign cand[g] = base + (PA_W'(idx) << ENT_SHIFT);
    end

    always_comb begin
        addr = '0;
        for (int unsigned k = 0; k < NUM_LVL; k++) begin
            if (lvl == LVL_W'(k)) addr = cand[k];
        end
    end

endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import ptw_pkg::*;
(
    input  logic [1:0]       type_bits,
    input  logic [LVL_W-1:0] lvl,
    output ent_kind_e        kind
);

    localparam logic [LVL_W-1:0] LAST = LVL_W'(NUM_LVL - 1);

    always_comb begin
        case (ent_type_e'(type_bits))
            ET_TABLE: kind = (lvl < LAST) ? K_DESCEND : K_FAULT;
            ET_MAP:   kind = K_MAP;
            default:  kind = K_FAULT;
        endcase
    end

endmodule

// File: rtl/ptw_pa_compose.sv
module ptw_pa_compose
    import ptw_pkg::*;
(
    input  logic [PA_W-1:0]  entry,
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] lvl,
    output logic [PA_W-1:0]  paddr
);

    logic [PA_W-1:0] cand [NUM_LVL];

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        localparam int unsigned   SH   = lvl_shift(g);
        localparam logic [PA_W-1:0] MASK = (PA_W'(1) << SH) - PA_W'(1);
        assign cand[g] = (entry & ~MASK) | (PA_W'(va) & MASK);
    end

    always_comb begin
        paddr = '0;
        for (int unsigned k = 0; k < NUM_LVL; k++) begin
            if (lvl == LVL_W'(k)) paddr = cand[k];
        end
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] root_ptr,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    output logic        busy,
    output logic        done,
    output logic [31:0] done_paddr,
    output logic        done_fault,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);

    walk_t     walk_d, walk_q;
    ent_kind_e kind;
    logic [PA_W-1:0] map_pa;
    logic [PA_W-1:0] ent_addr;

    ptw_entry_addr u_addr (
        .base (walk_q.base),
        .va   (walk_q.va),
        .lvl  (walk_q.lvl),
        .addr (ent_addr)
    );

    ptw_entry_decode u_dec (
        .type_bits (mem_rsp_data[1:0]),
        .lvl       (walk_q.lvl),
        .kind      (kind)
    );

    ptw_pa_compose u_pa (
        .entry (mem_rsp_data),
        .va    (walk_q.va),
        .lvl   (walk_q.lvl),
        .paddr (map_pa)
    );

    always_comb begin
        walk_d      = walk_q;
        walk_d.done = 1'b0;
        case (walk_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    walk_d.st   = S_ISSUE;
                    walk_d.lvl  = '0;
                    walk_d.base = root_ptr;
                    walk_d.va   = req_vaddr;
                end
            end
            S_ISSUE: begin
                if (mem_req_ready) walk_d.st = S_AWAIT;
            end
            S_AWAIT: begin
                if (mem_rsp_valid) begin
                    case (kind)
                        K_DESCEND: begin
                            walk_d.st   = S_ISSUE;
                            walk_d.lvl  = walk_q.lvl + LVL_W'(1);
                            walk_d.base = {mem_rsp_data[PA_W-1:ENT_SHIFT], {ENT_SHIFT{1'b0}}};
                        end
                        K_MAP: begin
                            walk_d.st    = S_IDLE;
                            walk_d.done  = 1'b1;
                            walk_d.fault = 1'b0;
                            walk_d.paddr = map_pa;
                        end
                        default: begin
                            walk_d.st    = S_IDLE;
                            walk_d.done  = 1'b1;
                            walk_d.fault = 1'b1;
                            walk_d.paddr = '0;
                        end
                    endcase
                end
            end
            default: walk_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '{st: S_IDLE, lvl: '0, base: '0, va: '0,
                        done: 1'b0, fault: 1'b0, paddr: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    assign busy          = (walk_q.st != S_IDLE);
    assign done          = walk_q.done;
    assign done_paddr    = walk_q.paddr;
    assign done_fault    = walk_q.fault;
    assign mem_req_valid = (walk_q.st == S_ISSUE);
    assign mem_req_addr  = ent_addr;

    // R1: no memory traffic when no walk is running
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid);

    // R2: an idle request starts a walk on the next cycle
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R2: a walk in flight keeps its virtual address
    p_va_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(walk_q.va));

    // R5: request held with stable address until taken
    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R9: a fault reports a zero address
    p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault) |-> (done_paddr == '0));

    // R8: page offset always passes through on success
    p_offset_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_fault) |-> (done_paddr[PG_OFF_W-1:0] == walk_q.va[PG_OFF_W-1:0]));

    // R11: completion is a single-cycle pulse and leaves the block idle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy || $past(req_valid)) ##1 !done);

endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;

    localparam logic [31:0] ROOT = 32'h0000_1C00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_ptr = ROOT;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        busy, done, done_fault, mem_req_valid;
    logic [31:0] done_paddr, mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int rsp_cyc = 0;
    int nlog = 0;
    logic [31:0] alog [4];
    logic [31:0] bmem [2048];

    always #10 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n), .root_ptr(root_ptr),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .busy(busy), .done(done), .done_paddr(done_paddr), .done_fault(done_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Memory model: random ready stalls and response latency, logs addresses.
    initial begin
        logic [31:0] a;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_req_ready = ($urandom % 4) != 0;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                a = mem_req_addr;
                if (nlog < 4) alog[nlog] = a;
                nlog++;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat ($urandom % 3) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = bmem[a[12:2]];
                rsp_cyc       = cyc;
            end
        end
    end

    function automatic logic [31:0] mkva(input int l1, input int l2, input int l3, input int off);
        return (32'(l1) << 24) | (32'(l2) << 18) | (32'(l3) << 12) | 32'(off);
    endfunction

    // Expected walk from the requirements (R3..R10).
    function automatic void ref_walk(input logic [31:0] va, output logic [31:0] pa,
                                     output bit flt, output int n, output logic [31:0] ea [3]);
        logic [31:0] base, e, idx, mask;
        base = ROOT; pa = '0; flt = 1'b1; n = 0;
        for (int l = 0; l < 3; l++) ea[l] = '0;
        for (int l = 0; l < 3; l++) begin
            idx  = (l == 0) ? 32'(va[31:24]) : (l == 1) ? 32'(va[23:18]) : 32'(va[17:12]);
            mask = (l == 0) ? 32'h00FF_FFFF : (l == 1) ? 32'h0003_FFFF : 32'h0000_0FFF;
            ea[l] = base + idx * 4;
            n++;
            e = bmem[ea[l][12:2]];
            if (e[1:0] == 2'd2) begin
                pa = (e & ~mask) | (va & mask);
                flt = 1'b0;
                return;
            end else if (e[1:0] == 2'd1 && l < 2) begin
                base = {e[31:2], 2'b00};
            end else begin
                return;
            end
        end
    endfunction

    task automatic run_walk(input logic [31:0] va, input string rq, input bit poke);
        logic [31:0] epa;
        bit ef;
        int en, waitc;
        logic [31:0] eea [3];
        ref_walk(va, epa, ef, en, eea);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; nlog = 0;
        @(negedge clk);
        if (poke) req_vaddr = ~va; else req_valid = 1'b0;
        chk(busy == 1'b1, "R2", "busy after accept", 32'(busy), 32'd1);
        if (poke) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
        waitc = 0;
        while (!done && waitc < 100) begin
            @(negedge clk);
            waitc++;
        end
        if (!done) begin
            chk(1'b0, rq, "walk timed out", 32'(waitc), 32'd100);
            return;
        end
        chk(done_fault == ef, rq, "fault flag", 32'(done_fault), 32'(ef));
        chk(done_paddr == epa, rq, "physical address", done_paddr, epa);
        if (poke) chk(done_paddr == epa && done_fault == ef, "R2", "busy request ignored", done_paddr, epa);
        chk(nlog == en, "R5", "read count", 32'(nlog), 32'(en));
        for (int i = 0; i < en && i < nlog && i < 3; i++)
            chk(alog[i] == eea[i], (i == 0) ? "R3" : "R4", "entry address", alog[i], eea[i]);
        chk(cyc == rsp_cyc + 1, "R11", "done timing", 32'(cyc), 32'(rsp_cyc + 1));
        @(negedge clk);
        chk(done == 1'b0, "R11", "done one cycle", 32'(done), 32'd0);
        chk(busy == 1'b0, "R2", "idle after done", 32'(busy), 32'd0);
    endtask

    function automatic logic [31:0] rnd_entry(input int lvl);
        int r;
        logic [31:0] w;
        r = $urandom % 100;
        w = $urandom;
        if (r < 10)      return w & 32'hFFFF_FFFC;
        else if (r < 20) return w | 32'h3;
        else if (r < 50) return (w & 32'hFFFF_FFFC) | 32'h2;
        else if (lvl == 0) return 32'h400 + 32'($urandom % 8) * 32'h100 + 32'h1;
        else if (lvl == 1) return 32'hC00 + 32'($urandom % 16) * 32'h100 + 32'h1;
        else               return 32'h1C00 + 32'h1;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2048; i++) bmem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(busy == 1'b0, "R1", "busy in reset", 32'(busy), 32'd0);
        chk(done == 1'b0, "R1", "done in reset", 32'(done), 32'd0);
        chk(mem_req_valid == 1'b0, "R1", "req in reset", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && mem_req_valid == 1'b0, "R1", "idle after reset", 32'(busy), 32'd0);

        // Directed tables
        bmem[(ROOT >> 2) + 32'h10] = 32'hAB12_3456;          // level-1 map
        bmem[(ROOT >> 2) + 32'h20] = 32'h0000_0401;          // pointer to 0x400
        bmem[(ROOT >> 2) + 32'h30] = 32'h0000_0000;          // invalid
        bmem[(ROOT >> 2) + 32'h31] = 32'h5555_5557;          // type 3
        bmem[(32'h400 >> 2) + 5]   = 32'h1234_5672;          // level-2 map
        bmem[(32'h400 >> 2) + 6]   = 32'h0000_0801;          // pointer to 0x800
        bmem[(32'h400 >> 2) + 7]   = 32'h0000_0003;          // type 3
        bmem[(32'h800 >> 2) + 7]   = 32'hCAFE_B00E;          // level-3 map
        bmem[(32'h800 >> 2) + 8]   = 32'h0000_0901;          // pointer at level 3
        bmem[(32'h800 >> 2) + 9]   = 32'h0000_0000;          // invalid at level 3

        run_walk(mkva(16'h10, 6'h2A, 6'h15, 12'hDEF), "R6", 1'b0);
        run_walk(mkva(16'h20, 5, 6'h3F, 12'h123), "R7", 1'b0);
        run_walk(mkva(16'h20, 6, 7, 12'hFFF), "R8", 1'b0);
        run_walk(mkva(16'h20, 6, 7, 12'h000), "R8", 1'b1);
        run_walk(mkva(16'h30, 1, 1, 12'h111), "R9", 1'b0);
        run_walk(mkva(16'h31, 1, 1, 12'h111), "R9", 1'b0);
        run_walk(mkva(16'h20, 7, 0, 12'h222), "R9", 1'b0);
        run_walk(mkva(16'h20, 6, 9, 12'h333), "R9", 1'b0);
        run_walk(mkva(16'h20, 6, 8, 12'h444), "R10", 1'b0);
        run_walk(mkva(16'h10, 0, 0, 12'h000), "R6", 1'b1);

        // R12: random tables and addresses
        for (int i = 0; i < 256; i++) bmem[(ROOT >> 2) + 32'(i)] = rnd_entry(0);
        for (int i = 0; i < 8 * 64; i++)  bmem[(32'h400 >> 2) + 32'(i)] = rnd_entry(1);
        for (int i = 0; i < 16 * 64; i++) bmem[(32'hC00 >> 2) + 32'(i)] = rnd_entry(2);
        for (int i = 0; i < 200; i++) run_walk($urandom, "R12", (i % 10) == 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule